// File: doc/BRIEF.md
# Load Ordering Violation Detector

This block keeps a queue of in-flight loads in program order so that loads may issue speculatively ahead of older stores whose addresses are not yet known. Entries are allocated at dispatch and retire from the head at commit; a rollback trims entries off the young end. At dispatch each entry records the load's PC and the sequence tag of the next store to be dispatched, which places the load among the stores. When the load executes, its entry takes the address and, if the value came from a store by forwarding, that store's tag.

When a store executes, it searches the queue with its tag and address. A load matches if it has executed, is younger than the store and has the same address. A matching load that forwarded from a store at least as young as the searching store read the correct value and is passed over. Every other match is an ordering violation. One cycle later the block raises a flush request that names the oldest offending entry and its PC, for the squash logic outside the block.

A direct-mapped table, indexed by the low bits of the PC, learns from each flush. At dispatch it tells the scheduler to hold a load until all older stores have executed. Store tags are compared modulo their width, so the tag counter may wrap freely.

Top module: `loadViolationQueue`

## Requirements
- R1: After reset the queue is empty (`dispIdx` = 0, `lqFull` = 0), `flushValid` is 0, and `dispWait` is 0 for every PC.
- R2: A dispatch takes entry `dispIdx`, and the index of later dispatches advances by one modulo DEPTH. `lqFull` rises when DEPTH entries are live. A dispatch while full is ignored.
- R3: A commit frees the head entry and advances the head by one. A commit on an empty queue is ignored.
- R4: A rollback of N removes the min(N, live count) youngest entries, so `dispIdx` moves back by that amount. A dispatch in the same cycle as a rollback is ignored.
- R5: A store search with tag S and address A flags a violation on a live, executed entry whose address equals A and whose recorded next-store tag L satisfies S older than L. `flushValid`, `flushIdx` and `flushPc` show the result in the cycle after the search. An address mismatch flags nothing.
- R6: An entry that has not executed never matches. A load that is not younger than the searching store (S not older than L) never matches.
- R7: A matching load that forwarded from store tag F is not a violation when F is the same as S or younger than S. It is a violation when F is older than S.
- R8: When several entries violate in one search, `flushIdx` names the one nearest the head in program order, even when the queue wraps.
- R9: Each flush sets the predictor slot selected by the low PRED_BITS bits of `flushPc`, and the slot takes effect one cycle after the flush is visible. From then on `dispWait` is 1 for every PC with those low bits, and stays 0 for the other PCs.
- R10: Tag order is decided modulo 2^SEQ_W: a is older than b when bit SEQ_W-1 of (a - b) is 1, so results hold across tag wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Allocate an entry for a dispatching load |
| dispPc | input | PC_W | PC of the dispatching load (also the predictor lookup) |
| dispStoreTag | input | SEQ_W | Tag the next store to be dispatched will get |
| dispIdx | output | IDX_W | Entry the next dispatch will take |
| dispWait | output | 1 | The load at dispPc should wait for all older stores |
| lqFull | output | 1 | All entries are live |
| exeValid | input | 1 | A load executes |
| exeIdx | input | IDX_W | Entry of the executing load |
| exeAddr | input | ADDR_W | Address of the executing load |
| exeFwd | input | 1 | The load took its value from a store |
| exeFwdTag | input | SEQ_W | Tag of the store it forwarded from |
| stValid | input | 1 | A store executes and searches |
| stTag | input | SEQ_W | Tag of the searching store |
| stAddr | input | ADDR_W | Address of the searching store |
| commitValid | input | 1 | Retire the head entry |
| rbValid | input | 1 | Trim young entries |
| rbDrop | input | IDX_W+1 | Number of entries to trim |
| flushValid | output | 1 | Ordering violation detected |
| flushIdx | output | IDX_W | Oldest offending entry |
| flushPc | output | PC_W | PC of the oldest offending entry |

## Verification
The bench builds the block with four entries, 4-bit store tags and addresses, 6-bit PCs and a four-slot predictor. With 4-bit tags, the sweep over load position, store tag and forwarding tag crosses the tag wrap point, starting from two tag bases. With four entries the head can be moved off zero, so a multi-hit search makes the oldest-first choice run across the end of the array. A 6-bit PC allows every predictor lookup to be checked, both after reset and after training.

// File: rtl/lqPkg.sv
package lqPkg;

  typedef struct packed {
    logic alloc;
    logic retire;
    logic trim;
  } lqStrobe_t;

  // a is older than b when (a - b) is negative in w-bit modular arithmetic
  function automatic logic seqOlder(input logic [31:0] a, input logic [31:0] b,
                                    input int unsigned w);
    logic [31:0] diff;
    diff = a - b;
    return diff[w-1];
  endfunction

endpackage

// File: rtl/lqCtrl.sv
module lqCtrl
  import lqPkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dispValid,
  input  logic             commitValid,
  input  logic             rbValid,
  input  logic [IDX_W:0]   rbDrop,
  output lqStrobe_t        strobe,
  output logic [IDX_W-1:0] headIdx,
  output logic [IDX_W-1:0] tailIdx,
  output logic [DEPTH-1:0] liveMask,
  output logic             full
);
  localparam logic [IDX_W:0] CNT_FULL = (IDX_W+1)'(DEPTH);

  logic [IDX_W-1:0] head;
  logic [IDX_W:0]   count;
  logic [IDX_W:0]   avail;
  logic [IDX_W:0]   drop;

  always_comb begin
    strobe.retire = commitValid && (count != '0);
    avail         = count - (IDX_W+1)'(strobe.retire);
    drop          = '0;
    if (rbValid) drop = (rbDrop > avail) ? avail : rbDrop;
    strobe.trim   = drop != '0;
    strobe.alloc  = dispValid && !rbValid && (count != CNT_FULL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      head  <= '0;
      count <= '0;
    end else begin
      head  <= head + IDX_W'(strobe.retire);
      count <= avail - drop + (IDX_W+1)'(strobe.alloc);
    end
  end

  assign headIdx = head;
  assign tailIdx = head + count[IDX_W-1:0];
  assign full    = count == CNT_FULL;

  for (genvar i = 0; i < DEPTH; i++) begin : gLive
    assign liveMask[i] = {1'b0, IDX_W'(i) - head} < count;
  end

endmodule

// File: rtl/lqData.sv
module lqData
  import lqPkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int SEQ_W  = 6,
  parameter int PC_W   = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  lqStrobe_t         strobe,
  input  logic [IDX_W-1:0]  headIdx,
  input  logic [IDX_W-1:0]  tailIdx,
  input  logic [DEPTH-1:0]  liveMask,
  input  logic [SEQ_W-1:0]  dispStoreTag,
  input  logic [PC_W-1:0]   dispPc,
  input  logic              exeValid,
  input  logic [IDX_W-1:0]  exeIdx,
  input  logic [ADDR_W-1:0] exeAddr,
  input  logic              exeFwd,
  input  logic [SEQ_W-1:0]  exeFwdTag,
  input  logic              stValid,
  input  logic [SEQ_W-1:0]  stTag,
  input  logic [ADDR_W-1:0] stAddr,
  output logic              flushValid,
  output logic [IDX_W-1:0]  flushIdx,
  output logic [PC_W-1:0]   flushPc
);
  logic [DEPTH-1:0]  executed;
  logic [ADDR_W-1:0] addrArr   [DEPTH];
  logic [SEQ_W-1:0]  nextStArr [DEPTH];
  logic [SEQ_W-1:0]  fwdTagArr [DEPTH];
  logic [DEPTH-1:0]  fwdArr;
  logic [PC_W-1:0]   pcArr     [DEPTH];
  logic [DEPTH-1:0]  hit;
  logic              found;
  logic [IDX_W-1:0]  sel;
  logic [IDX_W-1:0]  pos;

  wire exeTake = exeValid && liveMask[exeIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      executed <= '0;
    end else begin
      if (exeTake) executed[exeIdx] <= 1'b1;
      if (strobe.alloc) executed[tailIdx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.alloc) begin
      nextStArr[tailIdx] <= dispStoreTag;
      pcArr[tailIdx]     <= dispPc;
    end
    if (exeTake) begin
      addrArr[exeIdx]   <= exeAddr;
      fwdArr[exeIdx]    <= exeFwd;
      fwdTagArr[exeIdx] <= exeFwdTag;
    end
  end

  // per-entry match: younger executed load, same address, not served by a
  // store at least as young as the searcher
  for (genvar i = 0; i < DEPTH; i++) begin : gHit
    assign hit[i] = stValid && liveMask[i] && executed[i] &&
                    (addrArr[i] == stAddr) &&
                    seqOlder(32'(stTag), 32'(nextStArr[i]), SEQ_W) &&
                    !(fwdArr[i] && !seqOlder(32'(fwdTagArr[i]), 32'(stTag), SEQ_W));
  end

  // oldest-first pick: walk from youngest position to head, last hit wins
  always_comb begin
    found = 1'b0;
    sel   = '0;
    pos   = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      pos = headIdx + IDX_W'(k);
      if (hit[pos]) begin
        found = 1'b1;
        sel   = pos;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flushValid <= 1'b0;
      flushIdx   <= '0;
      flushPc    <= '0;
    end else begin
      flushValid <= found;
      flushIdx   <= sel;
      flushPc    <= pcArr[sel];
    end
  end

endmodule

// File: rtl/lqPredictor.sv
module lqPredictor #(
  parameter int PC_W      = 16,
  parameter int PRED_BITS = 4,
  localparam int SETS     = 1 << PRED_BITS
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            trainValid,
  input  logic [PC_W-1:0] trainPc,
  input  logic [PC_W-1:0] lookupPc,
  output logic            waitFlag
);
  logic [SETS-1:0] slotValid;

  always_ff @(posedge clk) begin
    if (!rstN) slotValid <= '0;
    else if (trainValid) slotValid[trainPc[PRED_BITS-1:0]] <= 1'b1;
  end

  assign waitFlag = slotValid[lookupPc[PRED_BITS-1:0]];

endmodule

// File: rtl/loadViolationQueue.sv
module loadViolationQueue
  import lqPkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int ADDR_W    = 16,
  parameter int SEQ_W     = 6,
  parameter int PC_W      = 16,
  parameter int PRED_BITS = 4,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dispValid,
  input  logic [PC_W-1:0]   dispPc,
  input  logic [SEQ_W-1:0]  dispStoreTag,
  output logic [IDX_W-1:0]  dispIdx,
  output logic              dispWait,
  output logic              lqFull,
  input  logic              exeValid,
  input  logic [IDX_W-1:0]  exeIdx,
  input  logic [ADDR_W-1:0] exeAddr,
  input  logic              exeFwd,
  input  logic [SEQ_W-1:0]  exeFwdTag,
  input  logic              stValid,
  input  logic [SEQ_W-1:0]  stTag,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic              commitValid,
  input  logic              rbValid,
  input  logic [IDX_W:0]    rbDrop,
  output logic              flushValid,
  output logic [IDX_W-1:0]  flushIdx,
  output logic [PC_W-1:0]   flushPc
);
  lqStrobe_t        strobe;
  logic [IDX_W-1:0] headIdx;
  logic [DEPTH-1:0] liveMask;

  lqCtrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .commitValid(commitValid),
    .rbValid(rbValid), .rbDrop(rbDrop), .strobe(strobe), .headIdx(headIdx),
    .tailIdx(dispIdx), .liveMask(liveMask), .full(lqFull)
  );

  lqData #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .PC_W(PC_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .headIdx(headIdx), .tailIdx(dispIdx),
    .liveMask(liveMask), .dispStoreTag(dispStoreTag), .dispPc(dispPc),
    .exeValid(exeValid), .exeIdx(exeIdx), .exeAddr(exeAddr), .exeFwd(exeFwd),
    .exeFwdTag(exeFwdTag), .stValid(stValid), .stTag(stTag), .stAddr(stAddr),
    .flushValid(flushValid), .flushIdx(flushIdx), .flushPc(flushPc)
  );

  lqPredictor #(.PC_W(PC_W), .PRED_BITS(PRED_BITS)) uPred (
    .clk(clk), .rstN(rstN), .trainValid(flushValid), .trainPc(flushPc),
    .lookupPc(dispPc), .waitFlag(dispWait)
  );

endmodule

// File: rtl/lqChecker.sv
module lqChecker #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             dispValid,
  input logic             commitValid,
  input logic             rbValid,
  input logic             stValid,
  input logic             lqFull,
  input logic [IDX_W-1:0] dispIdx,
  input logic [DEPTH-1:0] liveMask,
  input logic             flushValid,
  input logic [IDX_W-1:0] flushIdx
);
  // R5: a flush only follows a store search
  p_flush_after_search_r5: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |-> $past(stValid));

  // R5: the named entry was live when the search ran
  p_flush_live_entry_r5: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |-> (($past(liveMask) & (DEPTH'(1) << flushIdx)) != '0));

  // R2: dispatch into a full queue changes nothing
  p_full_blocks_r2: assert property (@(posedge clk) disable iff (!rstN)
    (lqFull && dispValid && !commitValid && !rbValid) |=> (lqFull && $stable(dispIdx)));

  // R4: a rollback never grows the queue, even with a dispatch alongside
  p_rollback_no_grow_r4: assert property (@(posedge clk) disable iff (!rstN)
    rbValid |=> ($countones(liveMask) <= $countones($past(liveMask))));

  // R3: commit on an empty queue leaves it empty
  p_empty_commit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (commitValid && !dispValid && (liveMask == '0)) |=> (liveMask == '0));
endmodule

bind loadViolationQueue lqChecker #(.DEPTH(DEPTH), .IDX_W(IDX_W)) uChk (
  .clk(clk), .rstN(rstN), .dispValid(dispValid), .commitValid(commitValid),
  .rbValid(rbValid), .stValid(stValid), .lqFull(lqFull), .dispIdx(dispIdx),
  .liveMask(liveMask), .flushValid(flushValid), .flushIdx(flushIdx)
);

// File: tb/tb_loadViolationQueue.sv
module tb_loadViolationQueue;
  localparam int DEPTH = 4, ADDR_W = 4, SEQ_W = 4, PC_W = 6, PRED_BITS = 2;
  localparam int IDX_W = 2;

  logic clk = 0, rstN = 0;
  logic dispValid = 0, exeValid = 0, exeFwd = 0, stValid = 0, commitValid = 0, rbValid = 0;
  logic [PC_W-1:0]   dispPc = '0;
  logic [SEQ_W-1:0]  dispStoreTag = '0, exeFwdTag = '0, stTag = '0;
  logic [IDX_W-1:0]  exeIdx = '0;
  logic [ADDR_W-1:0] exeAddr = '0, stAddr = '0;
  logic [IDX_W:0]    rbDrop = '0;
  logic [IDX_W-1:0]  dispIdx, flushIdx;
  logic dispWait, lqFull, flushValid;
  logic [PC_W-1:0] flushPc;

  int checks = 0, fails = 0;
  int headM = 0, cntM = 0;

  always #5 clk = ~clk;

  loadViolationQueue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .PC_W(PC_W),
                       .PRED_BITS(PRED_BITS)) dut (.*);

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired: actual hung, expected finish");
    finishUp();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic doReset();
    rstN = 0; tick(); tick(); rstN = 1;
    headM = 0; cntM = 0;
  endtask

  function automatic int tailM();
    return (headM + cntM) % DEPTH;
  endfunction

  task automatic doDisp(input int pc, input int tag);
    dispValid = 1; dispPc = PC_W'(pc); dispStoreTag = SEQ_W'(tag);
    tick(); dispValid = 0;
    if (cntM < DEPTH) cntM++;
  endtask

  task automatic doExe(input int idx, input int addr, input bit fwd, input int ftag);
    exeValid = 1; exeIdx = IDX_W'(idx); exeAddr = ADDR_W'(addr);
    exeFwd = fwd; exeFwdTag = SEQ_W'(ftag);
    tick(); exeValid = 0;
  endtask

  task automatic doCommit();
    commitValid = 1; tick(); commitValid = 0;
    if (cntM > 0) begin headM = (headM + 1) % DEPTH; cntM--; end
  endtask

  task automatic doRollback(input int n, input bit withDisp);
    rbValid = 1; rbDrop = (IDX_W+1)'(n); dispValid = withDisp; dispPc = '0;
    tick(); rbValid = 0; dispValid = 0;
    cntM -= (n > cntM) ? cntM : n;
  endtask

  task automatic doSearch(input int tag, input int addr);
    stValid = 1; stTag = SEQ_W'(tag); stAddr = ADDR_W'(addr);
    tick(); stValid = 0;
  endtask

  initial begin
    doReset();
    // R1: reset state
    chk(dispIdx == 0, "R1 dispIdx", dispIdx, 0);
    chk(!lqFull, "R1 full", lqFull, 0);
    chk(!flushValid, "R1 flush", flushValid, 0);
    for (int p = 0; p < 64; p++) begin
      dispPc = PC_W'(p); #1;
      chk(!dispWait, "R1 dispWait", dispWait, 0);
    end

    // R2: in-order allocation and full
    for (int k = 0; k < DEPTH; k++) begin
      chk(dispIdx == IDX_W'(tailM()), "R2 alloc index", dispIdx, tailM());
      doDisp(10 + k, 0);
    end
    chk(lqFull, "R2 full", lqFull, 1);
    doDisp(30, 0);
    chk(lqFull && dispIdx == IDX_W'(tailM()), "R2 dispatch while full", dispIdx, tailM());
    // R3: commit frees head
    doCommit();
    chk(!lqFull, "R3 commit clears full", lqFull, 0);
    chk(dispIdx == IDX_W'(tailM()), "R3 tail after commit", dispIdx, tailM());
    doCommit(); doCommit(); doCommit();
    doCommit(); // on empty: ignored
    doDisp(1, 0);
    chk(dispIdx == IDX_W'(tailM()), "R3 empty commit ignored", dispIdx, tailM());
    // R4: rollback with dispatch in same cycle, then clamped rollback
    doDisp(2, 0); doDisp(3, 0);
    doRollback(2, 1);
    chk(dispIdx == IDX_W'(tailM()), "R4 rollback by two", dispIdx, tailM());
    doRollback(7, 0);
    chk(dispIdx == IDX_W'(headM), "R4 clamped rollback", dispIdx, headM);
    for (int k = 0; k < DEPTH; k++) doDisp(k, 0);
    chk(lqFull, "R4 exact capacity after rollback", lqFull, 1);
    doRollback(7, 0);

    // R5 R6 R7 R10: sweep over tag base, store offset, forward offset, execution
    for (int b = 0; b < 2; b++) begin
      for (int ds = -3; ds <= 2; ds++) begin
        for (int fm = 0; fm < 4; fm++) begin
          for (int ex = 0; ex < 2; ex++) begin
            int base = b ? 13 : 0;
            int idx = tailM();
            int pc = 40 + idx;
            bit exp;
            doDisp(pc, base);
            if (ex) doExe(idx, 9, fm != 0, (base - fm) & 15);
            exp = ex && (ds < 0) && !((fm != 0) && (-fm >= ds));
            doSearch((base + ds) & 15, 9);
            chk(flushValid == exp, "R7 R10 violation filter", flushValid, exp);
            if (exp) begin
              chk(flushIdx == IDX_W'(idx), "R5 flush index", flushIdx, idx);
              chk(flushPc == PC_W'(pc), "R5 flush pc", flushPc, pc);
            end
            if (!ex) chk(!flushValid, "R6 unexecuted never matches", flushValid, 0);
            doSearch((base + ds) & 15, 8);
            chk(!flushValid, "R5 address mismatch", flushValid, 0);
            doRollback(7, 0);
          end
        end
      end
    end

    // R8: oldest offender across wrap
    doReset();
    doDisp(0, 0); doDisp(0, 0); doCommit(); doCommit();
    for (int k = 0; k < DEPTH; k++) doDisp(20 + k, 1); // entries 2,3,0,1
    doExe(3, 5, 0, 0); doExe(0, 5, 0, 0); doExe(1, 5, 0, 0);
    doSearch(0, 5);
    chk(flushValid && flushIdx == 3, "R8 oldest index", flushIdx, 3);
    chk(flushPc == 21, "R8 oldest pc", flushPc, 21);
    doExe(2, 5, 0, 0);
    doSearch(0, 5);
    chk(flushValid && flushIdx == 2, "R8 head entry oldest", flushIdx, 2);
    doExe(2, 5, 1, 0);
    doSearch(15, 5);
    chk(flushValid && flushIdx == 3, "R7 R8 forwarded head skipped", flushIdx, 3);

    // R9: predictor training
    doReset();
    dispPc = 6; #1;
    chk(!dispWait, "R1 predictor cleared", dispWait, 0);
    doDisp(6, 2);
    doExe(0, 3, 0, 0);
    doSearch(1, 3);
    chk(flushValid && flushPc == 6, "R9 flush pc", flushPc, 6);
    tick();
    for (int p = 0; p < 64; p++) begin
      dispPc = PC_W'(p); #1;
      chk(dispWait == ((p % 4) == 2), "R9 wait flag", dispWait, (p % 4) == 2);
    end

    finishUp();
  end
endmodule